// File: doc/BRIEF.md
# Redundant-Stage Code Combiner for a Pipelined Converter

This block turns the raw decisions of a chain of 1.5-bit-per-stage pipeline converter stages into one binary output word. Each stage reports a two-bit code that says whether its input was below, between or above its two comparison levels (minus and plus a quarter of the reference). The chain has `NUM_STAGES` stages. Because the stages sample on alternating phases, the code for a given input sample appears at stage i exactly i clock cycles after it appears at stage 0.

Inside, a triangle of skew registers delays each stage's code by enough cycles to line up all the codes of one sample. The codes are then added with a one-bit overlap. The first stage's code has the most weight, and each later stage sits one bit position lower than the stage before it. The lowest bit of that sum is dropped, and the remaining `NUM_STAGES` bits are registered as the corrected word. Because the codes overlap, a stage whose comparator decided slightly wrong is repaired by the carry from the stage after it.

The converter front end drives `in_vld` alongside stage 0's code for a sample and keeps feeding the later stages' codes on the following cycles. `out_vld` and `out_word` follow a fixed latency later.

Top module: `pdc_corrector`

## Requirements
- R1: A synchronous active-high reset clears `out_vld`, `out_word` and `code_err` to zero on the next clock edge.
- R2: `out_vld` rises exactly `NUM_STAGES` cycles after `in_vld` is presented with stage 0's code, and it mirrors every `in_vld` pattern with that delay.
- R3: Stage i occupies bits [2i+1:2i] of `stage_codes`, and stage 0 is the first (most significant) stage. The codes are 2'b00 for below the lower level, 2'b01 for between the levels, and 2'b10 for above the upper level. The word is bits [NUM_STAGES:1] of the sum over i of code_i shifted left by NUM_STAGES-1-i.
- R4: The code for a sample is taken from stage i in the cycle i clock cycles after that sample's `in_vld` cycle. Codes driven on other cycles do not enter that sample's word.
- R5: Samples presented on consecutive cycles produce one corrected word per clock, with no gaps.
- R6: The unused code 2'b11 at any stage of a valid sample sets `code_err`. The flag rises in the same cycle that sample's word appears, and it stays high until reset.
- R7: A stage code of 2'b11 counts as 2'b10 in the sum.
- R8: While `out_vld` is low, `out_word` holds its last value. Stage codes that belong to no valid sample, including 2'b11, change neither `out_word` nor `code_err`.
- R9: With every stage at 2'b10 the word is all ones (2^NUM_STAGES - 1), with no wrap-around. With every stage at 2'b00 the word is zero.
- R10: With three stages coded 10, 01, 10 from first to last, the sum is 4'b1100 and the word is 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Marks the cycle in which stage 0's code of a new sample is presented |
| stage_codes | input | 2*NUM_STAGES | Current two-bit code of every stage, stage i at bits [2i+1:2i] |
| out_vld | output | 1 | Corrected word is valid this cycle |
| out_word | output | NUM_STAGES | Corrected binary word, held between valid cycles |
| code_err | output | 1 | Sticky flag: a valid sample carried the unused code 2'b11 |

## Verification
A skew register with the wrong depth or wrong ordering pairs codes from different samples. Such a fault shows at the ports `NUM_STAGES` cycles after the affected sample, as a word off by the weight of the misplaced stage. It is caught only when neighbouring samples differ, so the stimulus streams different input levels back to back and also with gaps. A broken valid pipeline shows at once as `out_vld` one cycle early or late, or as a word that changes while `out_vld` is low. A faulty error flag shows either as `code_err` rising on idle junk codes or as the flag clearing before the next reset.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        SEG_LOW  = 2'b00,
        SEG_MID  = 2'b01,
        SEG_HIGH = 2'b10,
        SEG_BAD  = 2'b11
    } seg_code_e;

    typedef struct packed {
        logic       bad;
        logic [1:0] digit;
    } seg_clean_t;

    // Map a raw stage decision to the digit used in the overlapped sum.
    // The unused pattern is flagged and folded onto the top decision.
    function automatic seg_clean_t clean_code(input logic [1:0] raw);
        seg_clean_t r;
        unique case (seg_code_e'(raw))
            SEG_LOW: begin
                r.bad   = 1'b0;
                r.digit = SEG_LOW;
            end
            SEG_MID: begin
                r.bad   = 1'b0;
                r.digit = SEG_MID;
            end
            SEG_HIGH: begin
                r.bad   = 1'b0;
                r.digit = SEG_HIGH;
            end
            default: begin
                r.bad   = 1'b1;
                r.digit = SEG_HIGH;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pdc_skew_delay.sv
module pdc_skew_delay #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] taps [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) begin
                taps[j] <= '0;
            end
        end else begin
            taps[0] <= din;
            for (int j = 1; j < DEPTH; j++) begin
                taps[j] <= taps[j-1];
            end
        end
    end

    assign dout = taps[DEPTH-1];

endmodule

// File: rtl/pdc_code_clean.sv
module pdc_code_clean
    import pdc_pkg::*;
#(
    parameter int NUM_STAGES = 3
) (
    input  logic [2*NUM_STAGES-1:0] raw_codes,
    output logic [2*NUM_STAGES-1:0] digits,
    output logic [NUM_STAGES-1:0]   bad_flags
);

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        seg_clean_t cleaned;
        assign cleaned            = clean_code(raw_codes[2*g +: 2]);
        assign digits[2*g +: 2]   = cleaned.digit;
        assign bad_flags[g]       = cleaned.bad;
    end

endmodule

// File: rtl/pdc_overlap_sum.sv
module pdc_overlap_sum #(
    parameter int NUM_STAGES = 3
) (
    input  logic [2*NUM_STAGES-1:0] digits,
    output logic [NUM_STAGES:0]     total
);

    localparam int SUM_W = NUM_STAGES + 1;

    always_comb begin
        logic [SUM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            acc = acc + ({{(SUM_W-2){1'b0}}, digits[2*i +: 2]} << (NUM_STAGES - 1 - i));
        end
        total = acc;
    end

endmodule

// File: rtl/pdc_corrector.sv
module pdc_corrector #(
    parameter int NUM_STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [2*NUM_STAGES-1:0] stage_codes,
    output logic                    out_vld,
    output logic [NUM_STAGES-1:0]   out_word,
    output logic                    code_err
);

    localparam int CODE_W  = 2 * NUM_STAGES;
    localparam int SUM_W   = NUM_STAGES + 1;
    localparam int VLD_DLY = NUM_STAGES - 1;

    logic [CODE_W-1:0]     aligned_codes;
    logic [CODE_W-1:0]     clean_digits;
    logic [NUM_STAGES-1:0] bad_flags;
    logic [SUM_W-1:0]      raw_sum;
    logic                  aligned_vld;
    logic                  lsb_unused;

    // Earlier stages wait longer so every code of one sample meets at the adder.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_align
        localparam int DLY = NUM_STAGES - 1 - g;
        if (DLY > 0) begin : g_dly
            pdc_skew_delay #(
                .WIDTH(2),
                .DEPTH(DLY)
            ) u_dly (
                .clk (clk),
                .rst (rst),
                .din (stage_codes[2*g +: 2]),
                .dout(aligned_codes[2*g +: 2])
            );
        end else begin : g_pass
            assign aligned_codes[2*g +: 2] = stage_codes[2*g +: 2];
        end
    end

    pdc_skew_delay #(
        .WIDTH(1),
        .DEPTH(VLD_DLY)
    ) u_vld_dly (
        .clk (clk),
        .rst (rst),
        .din (in_vld),
        .dout(aligned_vld)
    );

    pdc_code_clean #(
        .NUM_STAGES(NUM_STAGES)
    ) u_clean (
        .raw_codes(aligned_codes),
        .digits   (clean_digits),
        .bad_flags(bad_flags)
    );

    pdc_overlap_sum #(
        .NUM_STAGES(NUM_STAGES)
    ) u_sum (
        .digits(clean_digits),
        .total (raw_sum)
    );

    assign lsb_unused = raw_sum[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_word <= '0;
            code_err <= 1'b0;
        end else begin
            out_vld <= aligned_vld;
            if (aligned_vld) begin
                out_word <= raw_sum[SUM_W-1:1];
                if (|bad_flags) begin
                    code_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pdc_corrector_chk.sv
module pdc_corrector_chk #(
    parameter int NUM_STAGES = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_vld,
    input logic                  out_vld,
    input logic [NUM_STAGES-1:0] out_word,
    input logic                  code_err
);

    logic [NUM_STAGES-1:0] vld_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_hist <= '0;
        end else begin
            vld_hist <= {vld_hist[NUM_STAGES-2:0], in_vld};
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && !code_err && out_word == '0));

    // R2
    vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld == vld_hist[NUM_STAGES-1]);

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> $stable(out_word));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err);

    // R6
    err_with_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(code_err) |-> out_vld);

endmodule

bind pdc_corrector pdc_corrector_chk #(
    .NUM_STAGES(NUM_STAGES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_word(out_word),
    .code_err(code_err)
);

// File: tb/sim_pdc_corrector.sv
module sim_pdc_corrector;

    localparam int K       = 3;
    localparam int VREF_MV = 2000;
    localparam int MAXS    = 64;
    localparam int NTBL    = 12;

    // input level in millivolts (reference 2000 mV) and the expected word
    localparam int TBL_VIN [NTBL] = '{1230, 0, 1999, -1999, 600, -600,
                                      500, -500, 1000, -1000, 250, -1300};
    localparam int TBL_EXP [NTBL] = '{6, 3, 7, 0, 4, 2, 4, 2, 5, 1, 4, 1};

    logic           clk = 1'b0;
    logic           rst;
    logic           in_vld;
    logic [2*K-1:0] stage_codes;
    logic           out_vld;
    logic [K-1:0]   out_word;
    logic           code_err;

    int checks = 0;
    int errors = 0;

    logic [2*K-1:0] sc [MAXS];
    bit             sv [MAXS];
    int             se [MAXS];
    int             ns;
    bit             err_exp;
    int             hold_word;

    always #2 clk = ~clk;

    pdc_corrector #(.NUM_STAGES(K)) u0 (
        .clk        (clk),
        .rst        (rst),
        .in_vld     (in_vld),
        .stage_codes(stage_codes),
        .out_vld    (out_vld),
        .out_word   (out_word),
        .code_err   (code_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural stand-in for the analog stage chain.
    function automatic logic [2*K-1:0] model_codes(input int vin);
        logic [2*K-1:0] c;
        int v;
        v = vin;
        c = '0;
        for (int i = 0; i < K; i++) begin
            if (4 * v > VREF_MV) begin
                c[2*i +: 2] = 2'b10;
                v = 2 * v - VREF_MV;
            end else if (4 * v < -VREF_MV) begin
                c[2*i +: 2] = 2'b00;
                v = 2 * v + VREF_MV;
            end else begin
                c[2*i +: 2] = 2'b01;
                v = 2 * v;
            end
        end
        return c;
    endfunction

    function automatic int spec_word(input logic [2*K-1:0] c);
        int acc;
        acc = 0;
        for (int i = 0; i < K; i++) begin
            int d;
            d = int'(c[2*i +: 2]);
            if (d == 3) d = 2;
            acc += d << (K - 1 - i);
        end
        return acc >> 1;
    endfunction

    function automatic bit has_bad(input logic [2*K-1:0] c);
        bit b;
        b = 1'b0;
        for (int i = 0; i < K; i++) begin
            if (c[2*i +: 2] == 2'b11) b = 1'b1;
        end
        return b;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        stage_codes = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        err_exp = 1'b0;
        hold_word = 0;
        check(out_vld == 1'b0, "R1", "out_vld after reset", int'(out_vld), 0);
        check(out_word == '0, "R1", "out_word after reset", int'(out_word), 0);
        check(code_err == 1'b0, "R1", "code_err after reset", int'(code_err), 0);
    endtask

    // Stream ns samples with the stage skew; check every cycle.
    task automatic run_stream(input string req, input bit idle_junk);
        for (int c = 0; c < ns + K + 1; c++) begin
            int s;
            @(negedge clk);
            s = c - K;
            if (s >= 0 && s < ns && sv[s]) begin
                if (has_bad(sc[s])) err_exp = 1'b1;
                check(out_vld == 1'b1, req, "out_vld high (R2)", int'(out_vld), 1);
                check(int'(out_word) == se[s], req, "out_word", int'(out_word), se[s]);
                hold_word = se[s];
            end else begin
                check(out_vld == 1'b0, req, "out_vld low (R2)", int'(out_vld), 0);
                check(int'(out_word) == hold_word, "R8", "held out_word",
                      int'(out_word), hold_word);
            end
            check(code_err == err_exp, req, "code_err (R6)", int'(code_err), int'(err_exp));
            in_vld = (c < ns) ? sv[c] : 1'b0;
            for (int i = 0; i < K; i++) begin
                int slot;
                slot = c - i;
                if (slot >= 0 && slot < ns && sv[slot])
                    stage_codes[2*i +: 2] = sc[slot][2*i +: 2];
                else
                    stage_codes[2*i +: 2] = idle_junk ? 2'b11 : 2'b00;
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_vld = 1'b0;
        stage_codes = '0;
        err_exp = 1'b0;
        hold_word = 0;
        do_reset();

        // R10: required vector 10, 01, 10 from the stage model
        check(model_codes(1230) == 6'b10_01_10, "R10", "model codes",
              int'(model_codes(1230)), int'(6'b10_01_10));

        // Table walk: R3, R4, R10 (first entry), back to back
        ns = NTBL;
        for (int s = 0; s < NTBL; s++) begin
            sc[s] = model_codes(TBL_VIN[s]);
            sv[s] = 1'b1;
            se[s] = TBL_EXP[s];
        end
        run_stream("R3/R10", 1'b0);

        // R5: dense sweep, one word per clock
        ns = 30;
        for (int s = 0; s < 30; s++) begin
            sc[s] = model_codes(-1950 + 130 * s);
            sv[s] = 1'b1;
            se[s] = spec_word(sc[s]);
        end
        run_stream("R5", 1'b0);

        // R4/R8: gaps with junk 11 codes in idle slots
        ns = 24;
        for (int s = 0; s < 24; s++) begin
            sc[s] = model_codes(1800 - 160 * s);
            sv[s] = (s % 3) != 1;
            se[s] = spec_word(sc[s]);
        end
        run_stream("R4", 1'b1);

        // R9: extremes
        ns = 3;
        sc[0] = 6'b10_10_10; sv[0] = 1'b1; se[0] = 7;
        sc[1] = 6'b00_00_00; sv[1] = 1'b1; se[1] = 0;
        sc[2] = 6'b01_01_01; sv[2] = 1'b1; se[2] = 3;
        run_stream("R9", 1'b0);

        // R7/R6: stage 1 carries 11, counted as 10, flag rises and stays
        ns = 4;
        sc[0] = 6'b00_11_00; sv[0] = 1'b1; se[0] = 2;
        sc[1] = model_codes(0); sv[1] = 1'b1; se[1] = 3;
        sc[2] = 6'b11_00_00; sv[2] = 1'b0; se[2] = 0;
        sc[3] = 6'b11_11_11; sv[3] = 1'b1; se[3] = 7;
        run_stream("R7", 1'b0);
        check(code_err == 1'b1, "R6", "flag still set", int'(code_err), 1);

        // R1: reset clears the sticky flag
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule